// File: doc/BRIEF.md
# Merged Vector-Scalar Register File

The block is one register file that three instruction groups use as their own. It has 64 entries of 128 bits. Each entry is held as two doublewords that can be written apart: the high doubleword (bits 127:64 of the port data, the most significant end of the entry) and the low doubleword (bits 63:0). Scalar floating-point code sees 32 registers of 64 bits, placed in the high doubleword of entries 0 to 31. Legacy vector code sees 32 registers of 128 bits, placed in entries 32 to 63. The unified vector-scalar group can address all 64 entries directly.

Each entry carries two flags. The low-valid flag drops when a scalar write stores only the high half. A dirty flag marks scalar data held in a form only the floating-point unit understands. A vector read never shows a stale low half: an invalid low half reads as zero. A consumer outside the floating-point unit that reads a dirty entry gets a flush request instead of data. There is one write port and a parameterised number of read ports, two by default. Every access carries a 2-bit access class: 0 scalar FP, 1 unified, 2 legacy vector, 3 outside consumer. The outside-consumer class also covers fixed-point operands and single-precision vector operands.

Top module: `merged_vrf`

## Requirements
- R1: After reset every entry reads as all zeros with the low half valid and the dirty flag clear, so an outside-consumer read of any entry returns zero with no flush.
- R2: A scalar write (class 0) to index n stores wr_data[127:64] in the high half of entry n mod 32; index bit 5 is ignored.
- R3: A scalar write marks the low half of its entry invalid, so a later unified or legacy read returns zeros in bits 63:0.
- R4: A scalar read returns the high half of entry n mod 32 in bits 127:64 and zeros in bits 63:0, whatever the low half holds.
- R5: The legacy class (2) maps index n to entry 32 + (n mod 32) for both reads and writes.
- R6: The unified class (1) and the outside class (3) address entry idx directly over all 64 entries.
- R7: A write of class 1, 2 or 3 stores all 128 bits, sets the low-valid flag and clears the dirty flag.
- R8: A scalar write loads the entry's dirty flag from wr_dirty. A class 3 read of a dirty entry raises rd_flush with rd_data all zeros. Reads of classes 0, 1 and 2 of a dirty entry deliver data with no flush.
- R9: A read issued with rd_en in one cycle gives rd_vld and its data in the next cycle. A read of an entry being written in the same cycle returns the contents from before that write.
- R10: The read ports are independent: each returns its own entry and class result in the same cycle, even when both name the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_cls | input | 2 | Write access class |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 128 | Write data, high doubleword in bits 127:64 |
| wr_dirty | input | 1 | Dirty flag loaded by a scalar write |
| rd_en | input | NRD | Read request per port |
| rd_cls | input | 2*NRD | Read access class per port, port p in bits 2p+1:2p |
| rd_idx | input | 6*NRD | Read register index per port, port p in bits 6p+5:6p |
| rd_data | output | 128*NRD | Read data per port, port p in bits 128p+127:128p |
| rd_flush | output | NRD | Flush request per port, valid with rd_vld |
| rd_vld | output | NRD | Read result valid per port |

## Verification
Directed sequences run first. Reads just after reset separate the reset state from leftover memory content. Scalar writes with index bit 5 set, followed by unified and legacy reads of both possible entries, separate a correct view mapping from an aliased one. They also show whether the low half was invalidated. Writing and reading one entry in the same cycle separates read-before-write from write-through. A dirty entry read by both ports at once, with outside and FPU classes, separates flush gating by class from gating by entry. A long pseudo-random stream of mixed classes and indices, checked against a bench model, then catches flag interactions that the directed cases miss.

// File: rtl/merged_vrf_pkg.sv
package merged_vrf_pkg;
  typedef enum logic [1:0] {
    CLS_SCALAR  = 2'd0,
    CLS_UNIFIED = 2'd1,
    CLS_LEGACY  = 2'd2,
    CLS_OUTSIDE = 2'd3
  } acc_cls_e;
endpackage

// File: rtl/merged_vrf_map.sv
module merged_vrf_map
  import merged_vrf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [1:0]    cls,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] entry
);
  // scalar view sits in the lower half of the file, legacy view in the upper half
  always_comb begin
    unique case (acc_cls_e'(cls))
      CLS_SCALAR: entry = {1'b0, idx[AW-2:0]};
      CLS_LEGACY: entry = {1'b1, idx[AW-2:0]};
      default:    entry = idx;
    endcase
  end
endmodule

// File: rtl/merged_vrf_bank.sv
module merged_vrf_bank #(
  parameter int W     = 64,
  parameter int DEPTH = 64,
  parameter int NRD   = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  logic [NRD-1:0]    re,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rq  [NRD];

  // read-first memory: reads see contents from before a same-cycle write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    for (int p = 0; p < NRD; p++) begin
      if (re[p]) rq[p] <= mem[raddr[p*AW +: AW]];
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_out
    assign rdata[g*W +: W] = rq[g];
  end
endmodule

// File: rtl/merged_vrf_flags.sv
module merged_vrf_flags #(
  parameter int DEPTH = 64,
  parameter int NRD   = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              w_scalar,
  input  logic [AW-1:0]     waddr,
  input  logic              w_dirty,
  input  logic [NRD-1:0]    re,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD-1:0]    hi_on,
  output logic [NRD-1:0]    lo_on,
  output logic [NRD-1:0]    drt
);
  // hi_set/lo_set: half holds written data (otherwise it reads as zero)
  logic [DEPTH-1:0] hi_set, lo_set, lo_ok, dirty;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_set <= '0;
      lo_set <= '0;
      lo_ok  <= '1;
      dirty  <= '0;
      hi_on  <= '0;
      lo_on  <= '0;
      drt    <= '0;
    end else begin
      for (int p = 0; p < NRD; p++) begin
        if (re[p]) begin
          hi_on[p] <= hi_set[raddr[p*AW +: AW]];
          lo_on[p] <= lo_set[raddr[p*AW +: AW]] & lo_ok[raddr[p*AW +: AW]];
          drt[p]   <= dirty[raddr[p*AW +: AW]];
        end
      end
      if (we) begin
        hi_set[waddr] <= 1'b1;
        if (w_scalar) begin
          lo_ok[waddr] <= 1'b0;
          dirty[waddr] <= w_dirty;
        end else begin
          lo_set[waddr] <= 1'b1;
          lo_ok[waddr]  <= 1'b1;
          dirty[waddr]  <= 1'b0;
        end
      end
    end
  end

  // R7: a full-width write leaves its entry clean and low-valid
  assert_full_write_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (we && !w_scalar) |=> (!dirty[$past(waddr)] && lo_set[$past(waddr)]));
endmodule

// File: rtl/merged_vrf.sv
module merged_vrf
  import merged_vrf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 64,
  parameter int NRD   = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int EW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_cls,
  input  logic [AW-1:0]     wr_idx,
  input  logic [EW-1:0]     wr_data,
  input  logic              wr_dirty,
  input  logic [NRD-1:0]    rd_en,
  input  logic [2*NRD-1:0]  rd_cls,
  input  logic [AW*NRD-1:0] rd_idx,
  output logic [EW*NRD-1:0] rd_data,
  output logic [NRD-1:0]    rd_flush,
  output logic [NRD-1:0]    rd_vld
);
  logic [AW-1:0]     w_entry;
  logic              w_scalar;
  logic [AW*NRD-1:0] r_entry;
  logic [DW*NRD-1:0] hi_raw, lo_raw;
  logic [NRD-1:0]    hi_on, lo_on, drt;
  logic [NRD-1:0]    vld_q;
  logic [2*NRD-1:0]  cls_q;

  merged_vrf_map #(.DEPTH(DEPTH)) u_wmap (
    .cls(wr_cls), .idx(wr_idx), .entry(w_entry));

  assign w_scalar = (acc_cls_e'(wr_cls) == CLS_SCALAR);

  for (genvar g = 0; g < NRD; g++) begin : g_rmap
    merged_vrf_map #(.DEPTH(DEPTH)) u_rmap (
      .cls(rd_cls[2*g +: 2]), .idx(rd_idx[AW*g +: AW]), .entry(r_entry[AW*g +: AW]));
  end

  merged_vrf_bank #(.W(DW), .DEPTH(DEPTH), .NRD(NRD)) u_hi (
    .clk(clk), .we(wr_en), .waddr(w_entry), .wdata(wr_data[EW-1:DW]),
    .re(rd_en), .raddr(r_entry), .rdata(hi_raw));

  merged_vrf_bank #(.W(DW), .DEPTH(DEPTH), .NRD(NRD)) u_lo (
    .clk(clk), .we(wr_en && !w_scalar), .waddr(w_entry), .wdata(wr_data[DW-1:0]),
    .re(rd_en), .raddr(r_entry), .rdata(lo_raw));

  merged_vrf_flags #(.DEPTH(DEPTH), .NRD(NRD)) u_flags (
    .clk(clk), .rst(rst), .we(wr_en), .w_scalar(w_scalar), .waddr(w_entry),
    .w_dirty(wr_dirty), .re(rd_en), .raddr(r_entry),
    .hi_on(hi_on), .lo_on(lo_on), .drt(drt));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      cls_q <= '0;
    end else begin
      vld_q <= rd_en;
      cls_q <= rd_cls;
    end
  end

  assign rd_vld = vld_q;

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [DW-1:0] hi_v, lo_v;
    acc_cls_e      c;
    assign c    = acc_cls_e'(cls_q[2*g +: 2]);
    assign hi_v = hi_on[g] ? hi_raw[DW*g +: DW] : '0;
    assign lo_v = lo_on[g] ? lo_raw[DW*g +: DW] : '0;

    always_comb begin
      rd_flush[g] = 1'b0;
      if (c == CLS_SCALAR) begin
        rd_data[EW*g +: EW] = {hi_v, {DW{1'b0}}};
      end else if (c == CLS_OUTSIDE && drt[g]) begin
        rd_data[EW*g +: EW] = '0;
        rd_flush[g]         = vld_q[g];
      end else begin
        rd_data[EW*g +: EW] = {hi_v, lo_v};
      end
    end

    // R9: a result appears exactly one cycle after its request
    assert_vld_follows_en_R9: assert property (@(posedge clk) disable iff (rst)
      rd_en[g] |=> rd_vld[g]);
    assert_vld_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
      rd_vld[g] |-> $past(rd_en[g]));
    // R8: a flush carries no data and comes only from an outside-class read
    assert_flush_no_data_R8: assert property (@(posedge clk) disable iff (rst)
      rd_flush[g] |-> (rd_data[EW*g +: EW] == '0));
    assert_flush_outside_only_R8: assert property (@(posedge clk) disable iff (rst)
      rd_flush[g] |-> ($past(rd_cls[2*g +: 2]) == 2'd3));
    // R4: a scalar read never exposes the low doubleword
    assert_scalar_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_vld[g] && $past(rd_cls[2*g +: 2]) == 2'd0) |-> (rd_data[EW*g +: DW] == '0));
  end
endmodule

// File: tb/merged_vrf_tb.sv
module merged_vrf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NRD = 2;

  typedef struct {
    logic [127:0] data;
    logic         flush;
    string        tag;
  } exp_t;

  logic           clk = 0;
  logic           rst = 1;
  logic           wr_en = 0;
  logic [1:0]     wr_cls = 0;
  logic [5:0]     wr_idx = 0;
  logic [127:0]   wr_data = 0;
  logic           wr_dirty = 0;
  logic [1:0]     rd_en = 0;
  logic [3:0]     rd_cls = 0;
  logic [11:0]    rd_idx = 0;
  logic [255:0]   rd_data;
  logic [1:0]     rd_flush, rd_vld;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  exp_t q0[$];
  exp_t q1[$];

  logic [63:0] m_hi [64];
  logic [63:0] m_lo [64];
  logic        m_lv [64];
  logic        m_dt [64];

  merged_vrf #(.NRD(NRD)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cls(wr_cls), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_dirty(wr_dirty), .rd_en(rd_en), .rd_cls(rd_cls),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_flush(rd_flush), .rd_vld(rd_vld));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ent(int c, int i);
    if (c == 0) return i % 32;
    if (c == 2) return 32 + (i % 32);
    return i % 64;
  endfunction

  function automatic exp_t predict(int c, int i, string tag);
    exp_t e;
    int   n = ent(c, i);
    logic [63:0] l = m_lv[n] ? m_lo[n] : 64'h0;
    e.tag = tag;
    e.flush = 0;
    if (c == 0) e.data = {m_hi[n], 64'h0};
    else if (c == 3 && m_dt[n]) begin e.data = '0; e.flush = 1; end
    else e.data = {m_hi[n], l};
    return e;
  endfunction

  // one cycle of stimulus; expectations come from the model before the write
  task automatic step(input bit we, input int wc, input int wi, input logic [127:0] wd,
                      input bit wdt, input bit e0, input int c0, input int i0,
                      input bit e1, input int c1, input int i1, input string tag);
    @(posedge clk); #1;
    wr_en = we; wr_cls = wc[1:0]; wr_idx = wi[5:0]; wr_data = wd; wr_dirty = wdt;
    rd_en = {e1, e0};
    rd_cls = {c1[1:0], c0[1:0]};
    rd_idx = {i1[5:0], i0[5:0]};
    if (e0) q0.push_back(predict(c0, i0, tag));
    if (e1) q1.push_back(predict(c1, i1, tag));
    if (we) begin
      int n = ent(wc, wi);
      m_hi[n] = wd[127:64];
      if (wc == 0) begin m_lv[n] = 0; m_dt[n] = wdt; end
      else begin m_lo[n] = wd[63:0]; m_lv[n] = 1; m_dt[n] = 0; end
    end
  endtask

  task automatic idle();
    step(0, 0, 0, '0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic cmp(input int p, input exp_t e);
    logic [127:0] d = rd_data[128*p +: 128];
    n_cmp++;
    if (d !== e.data || rd_flush[p] !== e.flush) begin
      n_bad++;
      $display("FAIL %s port%0d: data=%h flush=%b expected data=%h flush=%b",
               e.tag, p, d, rd_flush[p], e.data, e.flush);
    end
  endtask

  // monitor: pops one expectation per valid result
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (rd_vld[0]) begin
          if (q0.size() == 0) begin n_cmp++; n_bad++; $display("FAIL R9 port0: unexpected valid, expected none"); end
          else cmp(0, q0.pop_front());
        end
        if (rd_vld[1]) begin
          if (q1.size() == 0) begin n_cmp++; n_bad++; $display("FAIL R9 port1: unexpected valid, expected none"); end
          else cmp(1, q1.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    n_cmp++;
    if (q0.size() != 0 || q1.size() != 0) begin
      n_bad++;
      $display("FAIL R9: pending results %0d/%0d, expected 0/0", q0.size(), q1.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1357_9bdf;
    for (int k = 0; k < 64; k++) begin m_hi[k] = 0; m_lo[k] = 0; m_lv[k] = 1; m_dt[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // reset state: no result valid while in reset
    n_cmp++;
    if (rd_vld !== 2'b00) begin n_bad++; $display("FAIL R1: rd_vld=%b expected 00", rd_vld); end
    rst = 0;

    // R1: reset contents read as zero, no flush
    step(0, 0, 0, '0, 0, 1, 1, 5, 1, 2, 7, "R1");
    step(0, 0, 0, '0, 0, 1, 3, 0, 1, 3, 63, "R1");
    // R6: unified full-range write and read
    step(1, 1, 10, {64'hA0A0_0000_1111_2222, 64'hA1A1_3333_4444_5555}, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(1, 1, 50, {64'h5050_5050_0000_0001, 64'h5151_5151_0000_0002}, 0, 1, 1, 10, 0, 0, 0, "R6");
    // R9: same-cycle read of the entry being written returns old data
    step(1, 1, 10, {64'hB0B0_0000_0000_0000, 64'hB1B1_0000_0000_0000}, 0, 1, 1, 10, 1, 3, 50, "R9");
    step(0, 0, 0, '0, 0, 1, 1, 10, 0, 0, 0, "R9");
    // R2/R3: scalar write with index bit 5 set lands in entry 3, low becomes invalid
    step(1, 1, 3, {64'hDDDD_0000_0000_0003, 64'hEEEE_0000_0000_0003}, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 35, {64'hC0C0_1234_5678_9ABC, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, '0, 0, 1, 1, 3, 1, 1, 35, "R3");
    // R5: legacy index 3 is entry 35, untouched by the scalar write
    step(0, 0, 0, '0, 0, 1, 2, 3, 1, 2, 35, "R5");
    // R4: scalar read hides a valid low half
    step(1, 1, 12, {64'h1212_0000_0000_0012, 64'h3434_0000_0000_0034}, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, '0, 0, 1, 0, 12, 1, 0, 44, "R4");
    // R5: legacy write index 4 reaches entry 36
    step(1, 2, 4, {64'h4444_0000_0000_0036, 64'h6666_0000_0000_0036}, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, '0, 0, 1, 1, 36, 1, 1, 4, "R5");
    // R8/R10: dirty scalar entry, outside read flushes, FPU read on other port does not
    step(1, 0, 6, {64'h6D6D_0000_0000_0006, 64'h0}, 1, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, '0, 0, 1, 3, 6, 1, 1, 6, "R10");
    step(0, 0, 0, '0, 0, 1, 0, 6, 1, 3, 6, "R8");
    // R7: full write clears dirty and revalidates low half
    step(1, 2, 6, {64'h7A7A_0000_0000_0000, 64'h7B7B_0000_0000_0000}, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 6, {64'h7C7C_0000_0000_0000, 64'h7D7D_0000_0000_0000}, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, '0, 0, 1, 3, 6, 1, 3, 38, "R7");
    // R3: a scalar write again invalidates a previously valid low half
    step(1, 0, 12, {64'h9999_0000_0000_0012, 64'h0}, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, '0, 0, 1, 1, 12, 1, 3, 12, "R3");
    idle();

    // mixed pseudo-random stream against the model
    for (int k = 0; k < 400; k++) begin
      logic [127:0] d;
      int wc, wi, c0, i0, c1, i1;
      bit we, wdt, e0, e1;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; we = lfsr[31]; wc = lfsr[29:28]; wi = lfsr[27:22]; wdt = lfsr[21];
      d[127:96] = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; e0 = lfsr[31]; c0 = lfsr[29:28]; i0 = lfsr[27:22];
      e1 = lfsr[20]; c1 = lfsr[19:18]; i1 = lfsr[17:12];
      d[95:64] = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; d[63:32] = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; d[31:0] = lfsr;
      step(we, wc, wi, d, wdt, e0, c0, i0, e1, c1, i1, "R10");
    end
    idle();
    idle();
    @(negedge clk);
    finish_run();
  end
endmodule